// File: doc/BRIEF.md
# Content-Addressable Lookup Cell

This block is one cell of a small associative lookup structure, such as the entries of a translation cache. It holds a single tag and a single payload word, and each has its own width parameter. A two-bit operation code selects what happens at each clock edge. A store operation loads a new tag and payload. A probe operation compares the presented tag with the held tag and records the outcome in a registered hit flag.

The held tag and payload are driven out continuously, so that an enclosing array can read them, steer them, or pick a victim for replacement without issuing any operation. The hit flag is sticky. It changes only on a probe or a store, and it keeps its value across idle cycles and across the spare operation code. An array built from these cells can therefore present a probe result for as long as it needs.

Top module: `cam_cell`

## Requirements
- R1: The op input is 2 bits wide, with these codes: 0 idle, 1 probe, 2 store, 3 spare. Every code is sampled on the rising clock edge.
- R2: A store (op=2) loads tag_in into the held tag and load_in into the held payload at that edge. Both are visible on the outputs from the next cycle on.
- R3: After a store, the hit output is 0.
- R4: A probe (op=1) whose tag_in equals the held tag sets hit to 1 from the next cycle on.
- R5: A probe whose tag_in differs from the held tag sets hit to 0, and the held tag and payload do not change.
- R6: A second store with a new tag and payload fully replaces the previous contents, and a following probe with the new tag reports a hit.
- R7: Tag width and payload width are independent parameters. The block works with them set to different values.
- R8: While op is idle (0), hit, the held tag and the held payload all keep their values.
- R9: The spare code (op=3) changes neither hit, nor the held tag, nor the held payload, whatever tag_in and load_in carry.
- R10: A synchronous active-low reset clears the held tag, the held payload and hit to 0 at the clock edge.
- R11: The held tag and payload are driven on tag_q and load_q at all times, with no operation needed to read them.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 2 | Operation code: 0 idle, 1 probe, 2 store, 3 spare |
| tag_in | input | TAG_W | Tag to store or to compare |
| load_in | input | LOAD_W | Payload to store |
| tag_q | output | TAG_W | Held tag |
| load_q | output | LOAD_W | Held payload |
| hit | output | 1 | Registered result of the last probe, cleared by a store |

## Verification
The assertions assume that op, tag_in and load_in are settled before each rising edge and hold a known value whenever rst_n is high. The stimulus meets this by changing every input on the falling edge only, and by giving every input a defined value from time zero. The properties also treat reset as the top priority and are switched off while it is asserted. The bench pulses reset in the middle of traffic, including the edge where a store is presented, so that the precedence of reset over a store is exercised.

// File: rtl/cam_cell_pkg.sv
// Package: shared operation codes for the lookup cell.
// Assumes: the op field is exactly two bits wide; the code values are fixed.
package cam_cell_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROBE = 2'd1,
        OP_STORE = 2'd2,
        OP_SPARE = 2'd3
    } cell_op_e;

endpackage

// File: rtl/cam_op_decode.sv
// Module: turns the raw two-bit op into one-hot strobes.
// Assumes: op is stable around the clock edge; idle and spare produce no strobe.
module cam_op_decode
    import cam_cell_pkg::*;
(
    input  logic [1:0] op,
    output logic       probe_en,
    output logic       store_en
);

    cell_op_e op_e;

    // Decode the operation code into strobes.
    always_comb begin
        op_e     = cell_op_e'(op);
        probe_en = 1'b0;
        store_en = 1'b0;
        case (op_e)
            OP_PROBE: probe_en = 1'b1;
            OP_STORE: store_en = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cam_tag_cmp.sv
// Module: equality comparator between the presented tag and the held tag.
// Assumes: both operands have the same width TAG_W.
module cam_tag_cmp #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] probe_tag,
    input  logic [TAG_W-1:0] held_tag,
    output logic             equal
);

    logic [TAG_W-1:0] diff;

    // Compare bit by bit; any differing bit breaks equality.
    always_comb begin
        diff  = probe_tag ^ held_tag;
        equal = ~(|diff);
    end

endmodule

// File: rtl/cam_store.sv
// Module: holding registers for the tag and the payload.
// Assumes: synchronous active-low reset; load strobe from the decoder.
module cam_store #(
    parameter int TAG_W  = 4,
    parameter int LOAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [TAG_W-1:0]  tag_d,
    input  logic [LOAD_W-1:0] load_d,
    output logic [TAG_W-1:0]  tag_r,
    output logic [LOAD_W-1:0] load_r
);

    // Capture the tag and payload on a store; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_r  <= '0;
            load_r <= '0;
        end else if (load_en) begin
            tag_r  <= tag_d;
            load_r <= load_d;
        end
    end

    // R2: a store shows up on the held registers after one edge.
    p_store_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (tag_r == $past(tag_d)) && (load_r == $past(load_d)));

endmodule

// File: rtl/cam_cell.sv
// Module: one associative lookup cell with a held tag, a held payload and a sticky hit flag.
// Assumes: inputs change away from the rising edge; synchronous active-low reset.
module cam_cell
    import cam_cell_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int LOAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [LOAD_W-1:0] load_in,
    output logic [TAG_W-1:0]  tag_q,
    output logic [LOAD_W-1:0] load_q,
    output logic              hit
);

    logic probe_en;
    logic store_en;
    logic tag_eq;
    logic hit_r;

    cam_op_decode u_dec (
        .op       (op),
        .probe_en (probe_en),
        .store_en (store_en)
    );

    cam_store #(.TAG_W(TAG_W), .LOAD_W(LOAD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (store_en),
        .tag_d   (tag_in),
        .load_d  (load_in),
        .tag_r   (tag_q),
        .load_r  (load_q)
    );

    cam_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .probe_tag (tag_in),
        .held_tag  (tag_q),
        .equal     (tag_eq)
    );

    // Sticky hit flag: set by a probe result, cleared by a store, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit_r <= 1'b0;
        else if (store_en)
            hit_r <= 1'b0;
        else if (probe_en)
            hit_r <= tag_eq;
    end

    assign hit = hit_r;

    // R3: a store leaves hit clear.
    p_store_clears_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2) |=> !hit);

    // R4: a probe with a matching tag raises hit.
    p_probe_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && tag_in == tag_q) |=> hit);

    // R5: a probe with a different tag clears hit and keeps the contents.
    p_probe_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && tag_in != tag_q) |=> (!hit && $stable(tag_q) && $stable(load_q)));

    // R8: idle holds everything.
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0) |=> ($stable(hit) && $stable(tag_q) && $stable(load_q)));

    // R9: the spare code holds everything.
    p_spare_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd3) |=> ($stable(hit) && $stable(tag_q) && $stable(load_q)));

    // R10: reset clears every output at the edge.
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (!hit && tag_q == '0 && load_q == '0));

endmodule

// File: tb/tb_cam_cell.sv
module tb_cam_cell;

    localparam int TW = 5;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [TW-1:0] tag_in = '0;
    logic [LW-1:0] load_in = '0;
    logic [TW-1:0] tag_q;
    logic [LW-1:0] load_q;
    logic          hit;

    int total = 0;
    int bad = 0;

    // Behavioural reference state
    int m_tag = 0;
    int m_load = 0;
    int m_hit = 0;

    always #10 clk = ~clk;

    cam_cell #(.TAG_W(TW), .LOAD_W(LW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .tag_in  (tag_in),
        .load_in (load_in),
        .tag_q   (tag_q),
        .load_q  (load_q),
        .hit     (hit)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic rn, input int c, input int k, input int d, input string req);
        @(negedge clk);
        rst_n   = rn;
        op      = 2'(c);
        tag_in  = TW'(k);
        load_in = LW'(d);
        @(posedge clk);
        if (!rn) begin
            m_tag = 0; m_load = 0; m_hit = 0;
        end else if (c == 2) begin
            m_tag = k % (1 << TW); m_load = d % (1 << LW); m_hit = 0;
        end else if (c == 1) begin
            m_hit = ((k % (1 << TW)) == m_tag) ? 1 : 0;
        end
        @(negedge clk);
        check(req, "tag_q", int'(tag_q), m_tag);
        check(req, "load_q", int'(load_q), m_load);
        check(req, "hit", int'(hit), m_hit);
    endtask

    initial begin
        step(1'b0, 0, 0, 0, "R10");
        step(1'b0, 2, 9, 9, "R10");
        step(1'b1, 2, 1, 1, "R2");
        step(1'b1, 0, 0, 0, "R3");
        step(1'b1, 1, 2, 1, "R5");
        step(1'b1, 1, 1, 1, "R4");
        step(1'b1, 0, 3, 3, "R8");
        step(1'b1, 3, 17, 99, "R9");
        step(1'b1, 3, 1, 44, "R9");
        step(1'b1, 2, 2, 5, "R6");
        step(1'b1, 1, 2, 5, "R6");
        step(1'b1, 2, 31, 127, "R7");
        step(1'b1, 1, 31, 0, "R7");
        step(1'b1, 1, 30, 0, "R5");
        step(1'b1, 2, 31, 1, "R3");
        step(1'b1, 1, 31, 0, "R11");
        for (int i = 0; i < 400; i++) begin
            int c;
            int k;
            c = int'($urandom_range(0, 3));
            k = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 31)) : m_tag;
            step((i % 97 == 50) ? 1'b0 : 1'b1, c, k, int'($urandom_range(0, 127)), "R1");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule